// File: doc/BRIEF.md
# Fail-safe reconfiguration update sequencer

This block copies a configuration image from external serial flash into the device's configuration memory. An update is done in two phases. First, another agent writes the new image into flash. Then a service request tells the sequencer which operation to run and where the image starts. The sequencer pulls the image through a byte-read handshake with a flash reader. It checks the device identifier and the additive checksum, then does one of three things: it only checks the image, it writes the payload into configuration memory, or it compares configuration memory with the image.

Programming is made safe against power loss by a persistent "update in progress" bit, which lives outside the block. The sequencer sets this bit before it writes the first word. It clears the bit only after the last word is written and the checksum has matched.

A power-fail input turns off the programming pump on the next clock and freezes the sequencer. After the next reset, a set bit makes the sequencer reprogram from the recovery image or from the update image, as a select input chooses. The user fabric is not released until that recovery completes cleanly.

Top module: `upd_sequencer`

## Requirements
- R1: Operation codes are 2'b01 check-only, 2'b10 program and 2'b11 verify. A request with code 2'b00 accepted while idle gives `done` on the next cycle with status 3. Status codes are 0 ok, 1 bad identifier, 2 bad checksum or compare mismatch, and 3 bad operation.
- R2: An image is a sequence of 32-bit words, each sent most significant byte first from increasing byte addresses. The words are: the identifier (`DEV_ID`), the payload length N, then N payload words, then a checksum equal to the 32-bit wrapping sum of the payload words. A well-formed image gives status 0 for a check-only request.
- R3: An image whose identifier differs from `DEV_ID`, or whose N exceeds `DEPTH`, ends with status 1 and causes no configuration write.
- R4: An image whose checksum differs from the payload sum ends with status 2.
- R5: A check-only request never writes configuration memory and leaves `fabric_rel` unchanged.
- R6: A program request writes payload word i to configuration address i, once per word, and only while `pump_en` is high.
- R7: During programming, `nv_set` pulses before the first configuration write. `nv_clr` pulses only after the last write, and only if the checksum matches. If the checksum fails, the persistent bit stays set.
- R8: A verify request reads configuration address i for each payload word i. Any difference, or a checksum failure, ends with status 2. Verify never writes.
- R9: If `power_fail` is high while `pump_en` is high, `pump_en` is low on the next cycle. The sequencer then stays busy and issues no further writes or flash reads until reset.
- R10: If the persistent bit is set at the end of reset, the sequencer reprograms before any request. It uses the image at `UPD_BASE` when `recov_sel` is 1 and the image at `GOLD_BASE` when it is 0.
- R11: `fabric_rel` is low on the cycle after any cycle in which the persistent bit reads set. Only one request runs at a time, and requests that arrive while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Service request strobe, taken when not busy |
| req_op | input | 2 | Operation code |
| req_addr | input | AW | Byte address of the image in flash |
| busy | output | 1 | A request or boot recovery is running |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result of the last completed request |
| fl_req | output | 1 | Byte read request to the flash reader |
| fl_addr | output | AW | Byte address being read |
| fl_ack | input | 1 | Byte returned on `fl_data` |
| fl_data | input | 8 | Returned byte |
| cfg_we | output | 1 | Configuration memory write strobe |
| cfg_addr | output | CW | Configuration word address for both writes and reads |
| cfg_wdata | output | 32 | Word to write |
| cfg_rdata | input | 32 | Word read at `cfg_addr` in the same cycle |
| pump_en | output | 1 | Programming pump enable |
| power_fail | input | 1 | Supply failing |
| nv_flag | input | 1 | Current value of the persistent in-progress bit |
| nv_set | output | 1 | Pulse that sets the persistent bit |
| nv_clr | output | 1 | Pulse that clears the persistent bit |
| recov_sel | input | 1 | Boot recovery source: 1 update image, 0 recovery image |
| fabric_rel | output | 1 | User fabric release |

## Verification
The checker tests several properties on every cycle. Each configuration write must happen with the pump on and the persistent bit set. The pump must drop one cycle after a power failure. A set persistent bit must hold the fabric in reset, and a check-only run must never write. A bad operation code must be answered on the next cycle. Some behaviour can only be shown by the bench's scenarios, because a single cycle cannot reveal it. This covers checksum and identifier decisions over a whole image, the contents left in configuration memory, and the freeze after a power failure. It also covers recovery across a reset from the selected image, and dropping a request that arrives mid-run.

// File: rtl/upd_pkg.sv
// Shared types for the update sequencer.
// Assumes 2-bit operation and status fields as listed in the brief.
package upd_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_AUTH   = 2'b01,
        OP_PROG   = 2'b10,
        OP_VERIFY = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BAD_ID  = 2'd1,
        ST_BAD_SUM = 2'd2,
        ST_BAD_OP  = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ID, S_LEN, S_BODY, S_SUM, S_END, S_HALT
    } seq_state_e;
endpackage

// File: rtl/upd_word_fetch.sv
// Assembles one 32-bit word from four flash bytes, most significant byte first.
// Assumes: fl_ack is a one-cycle pulse with the byte for the current fl_addr;
// go starts one word fetch, and load also restarts at base.
// abort cancels any fetch in flight.
module upd_word_fetch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          go,
    input  logic          load,
    input  logic [AW-1:0] base,
    output logic          fl_req,
    output logic [AW-1:0] fl_addr,
    input  logic          fl_ack,
    input  logic [7:0]    fl_data,
    output logic          w_vld,
    output logic [31:0]   w_data
);
    logic       active;
    logic [1:0] cnt;

    // Byte collection, address stepping and word-ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            fl_addr <= '0;
            w_data  <= '0;
            w_vld   <= 1'b0;
        end else if (abort) begin
            active <= 1'b0;
            w_vld  <= 1'b0;
        end else begin
            w_vld <= 1'b0;
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                if (load) fl_addr <= base;
            end else if (active && fl_ack) begin
                w_data  <= {w_data[23:0], fl_data};
                fl_addr <= fl_addr + 1'b1;
                cnt     <= cnt + 1'b1;
                if (cnt == 2'd3) begin
                    active <= 1'b0;
                    w_vld  <= 1'b1;
                end
            end
        end
    end

    assign fl_req = active;
endmodule

// File: rtl/upd_sum_acc.sv
// Wrapping additive checksum over payload words.
// Assumes clr and add are never high in the same cycle.
module upd_sum_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] val,
    output logic [W-1:0] sum
);
    // Running sum, cleared at the start of each image.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sum <= '0;
        else if (add)      sum <= sum + val;
    end
endmodule

// File: rtl/upd_sequencer.sv
// Update sequencer top: takes requests, walks the image, programs or compares
// configuration memory, guards the persistent in-progress bit, handles power
// failure and does recovery at power-up.
// Assumes nv_flag follows nv_set/nv_clr one cycle later and survives reset.
module upd_sequencer
    import upd_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DEPTH     = 16,
    parameter logic [31:0] DEV_ID    = 32'hC0DE_5A17,
    parameter logic [15:0] GOLD_BASE = 16'h0000,
    parameter logic [15:0] UPD_BASE  = 16'h0100,
    localparam int         CW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic          fl_req,
    output logic [AW-1:0] fl_addr,
    input  logic          fl_ack,
    input  logic [7:0]    fl_data,
    output logic          cfg_we,
    output logic [CW-1:0] cfg_addr,
    output logic [31:0]   cfg_wdata,
    input  logic [31:0]   cfg_rdata,
    output logic          pump_en,
    input  logic          power_fail,
    input  logic          nv_flag,
    output logic          nv_set,
    output logic          nv_clr,
    input  logic          recov_sel,
    output logic          fabric_rel
);
    localparam logic [31:0] DEPTH_W = 32'(DEPTH);

    seq_state_e    state;
    op_e           op;
    status_e       code;
    logic          boot_pend, go, load, mism, sum_clr, abort;
    logic [AW-1:0] base;
    logic [CW-1:0] idx, last_idx, wr_addr;
    logic          w_vld;
    logic [31:0]   w_data, sum;

    assign abort = pump_en && power_fail;

    upd_word_fetch #(.AW(AW)) fetch_i (
        .clk(clk), .rst_n(rst_n), .abort(abort), .go(go), .load(load),
        .base(base), .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack),
        .fl_data(fl_data), .w_vld(w_vld), .w_data(w_data)
    );

    upd_sum_acc #(.W(32)) sum_i (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr),
        .add(state == S_BODY && w_vld), .val(w_data), .sum(sum)
    );

    // Sequencing of the image walk, pump, persistent bit and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op        <= OP_NONE;
            code      <= ST_OK;
            status    <= ST_OK;
            boot_pend <= 1'b1;
            go        <= 1'b0;
            load      <= 1'b0;
            mism      <= 1'b0;
            sum_clr   <= 1'b0;
            base      <= '0;
            idx       <= '0;
            last_idx  <= '0;
            wr_addr   <= '0;
            cfg_we    <= 1'b0;
            cfg_wdata <= '0;
            pump_en   <= 1'b0;
            nv_set    <= 1'b0;
            nv_clr    <= 1'b0;
            done      <= 1'b0;
        end else begin
            go      <= 1'b0;
            load    <= 1'b0;
            sum_clr <= 1'b0;
            cfg_we  <= 1'b0;
            nv_set  <= 1'b0;
            nv_clr  <= 1'b0;
            done    <= 1'b0;
            if (abort) begin
                pump_en <= 1'b0;
                state   <= S_HALT;
            end else begin
                case (state)
                    S_IDLE: begin
                        if (boot_pend) begin
                            boot_pend <= 1'b0;
                            if (nv_flag) begin
                                op      <= OP_PROG;
                                base    <= recov_sel ? AW'(UPD_BASE) : AW'(GOLD_BASE);
                                go      <= 1'b1;
                                load    <= 1'b1;
                                mism    <= 1'b0;
                                sum_clr <= 1'b1;
                                state   <= S_ID;
                            end
                        end else if (req_valid) begin
                            if (req_op == OP_NONE) begin
                                done   <= 1'b1;
                                status <= ST_BAD_OP;
                            end else begin
                                op      <= op_e'(req_op);
                                base    <= req_addr;
                                go      <= 1'b1;
                                load    <= 1'b1;
                                mism    <= 1'b0;
                                sum_clr <= 1'b1;
                                state   <= S_ID;
                            end
                        end
                    end
                    S_ID: if (w_vld) begin
                        if (w_data != DEV_ID) begin
                            code  <= ST_BAD_ID;
                            state <= S_END;
                        end else begin
                            go    <= 1'b1;
                            state <= S_LEN;
                        end
                    end
                    S_LEN: if (w_vld) begin
                        if (w_data > DEPTH_W) begin
                            code  <= ST_BAD_ID;
                            state <= S_END;
                        end else begin
                            go       <= 1'b1;
                            idx      <= '0;
                            last_idx <= CW'(w_data - 32'd1);
                            if (w_data == 32'd0) begin
                                state <= S_SUM;
                            end else begin
                                state <= S_BODY;
                                if (op == OP_PROG) begin
                                    nv_set  <= 1'b1;
                                    pump_en <= 1'b1;
                                end
                            end
                        end
                    end
                    S_BODY: if (w_vld) begin
                        if (op == OP_PROG) begin
                            cfg_we    <= 1'b1;
                            wr_addr   <= idx;
                            cfg_wdata <= w_data;
                        end
                        if (op == OP_VERIFY && cfg_rdata != w_data) mism <= 1'b1;
                        go <= 1'b1;
                        if (idx == last_idx) state <= S_SUM;
                        else                 idx   <= idx + 1'b1;
                    end
                    S_SUM: if (w_vld) begin
                        pump_en <= 1'b0;
                        if (w_data != sum || mism) begin
                            code <= ST_BAD_SUM;
                        end else begin
                            code <= ST_OK;
                            if (op == OP_PROG) nv_clr <= 1'b1;
                        end
                        state <= S_END;
                    end
                    S_END: begin
                        done   <= 1'b1;
                        status <= code;
                        state  <= S_IDLE;
                    end
                    S_HALT: state <= S_HALT;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Fabric release: only after the boot check, and never while the bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) fabric_rel <= 1'b0;
        else        fabric_rel <= !boot_pend && !nv_flag;
    end

    assign busy     = (state != S_IDLE) || boot_pend;
    assign cfg_addr = cfg_we ? wr_addr : idx;
endmodule

// File: rtl/upd_sequencer_chk.sv
// Cycle-level properties of the update sequencer, bound to its top.
// Assumes only the top's ports; tracks the kind of the last accepted request.
module upd_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       cfg_we,
    input logic       pump_en,
    input logic       power_fail,
    input logic       nv_flag,
    input logic       fabric_rel
);
    logic auth_run;

    // Remembers whether the request now running is check-only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 auth_run <= 1'b0;
        else if (req_valid && !busy) auth_run <= (req_op == 2'b01);
    end

    // R1
    bad_op_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == 2'b00) |=> (done && status == 2'd3));
    // R5
    auth_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auth_run |-> !cfg_we);
    // R6
    write_pump_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> pump_en);
    // R7
    write_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> nv_flag);
    // R9
    pump_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en && power_fail) |=> (!pump_en && busy));
    // R9
    pump_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en |-> busy);
    // R11
    fabric_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_flag |=> !fabric_rel);
endmodule

bind upd_sequencer upd_sequencer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .busy(busy), .done(done), .status(status), .cfg_we(cfg_we),
    .pump_en(pump_en), .power_fail(power_fail), .nv_flag(nv_flag),
    .fabric_rel(fabric_rel)
);

// File: tb/upd_sequencer_tb_top.sv
// Bench for the update sequencer: models the flash, configuration memory and
// persistent bit, and predicts every result from the requirements.
module upd_sequencer_tb_top;
    localparam int          AW     = 16;
    localparam int          DEPTH  = 16;
    localparam int          CW     = $clog2(DEPTH);
    localparam logic [31:0] DEV_ID = 32'hC0DE_5A17;
    localparam int          GOLD   = 16'h0000;
    localparam int          UPD    = 16'h0100;
    localparam int          WORK   = 16'h0200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          busy, done;
    logic [1:0]    status;
    logic          fl_req;
    logic [AW-1:0] fl_addr;
    logic          fl_ack = 1'b0;
    logic [7:0]    fl_data = 8'h00;
    logic          cfg_we;
    logic [CW-1:0] cfg_addr;
    logic [31:0]   cfg_wdata, cfg_rdata;
    logic          pump_en;
    logic          power_fail = 1'b0;
    logic          nv_flag = 1'b0;
    logic          nv_set, nv_clr;
    logic          recov_sel = 1'b0;
    logic          fabric_rel;

    logic [7:0]  fmem [1024];
    logic [31:0] cmem [DEPTH];
    logic [31:0] exp_cfg [DEPTH];
    int          checks = 0, errors = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;

    always #4 clk = ~clk;

    upd_sequencer #(.AW(AW), .DEPTH(DEPTH), .DEV_ID(DEV_ID),
                    .GOLD_BASE(16'(GOLD)), .UPD_BASE(16'(UPD))) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .busy(busy), .done(done), .status(status),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_data(fl_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pump_en(pump_en), .power_fail(power_fail),
        .nv_flag(nv_flag), .nv_set(nv_set), .nv_clr(nv_clr),
        .recov_sel(recov_sel), .fabric_rel(fabric_rel)
    );

    // Flash reader model: one byte per request, acknowledged a cycle later.
    always @(posedge clk) begin
        fl_ack  <= fl_req && !fl_ack;
        fl_data <= fmem[fl_addr[9:0]];
    end
    // Configuration memory, persistent bit and event counters.
    assign cfg_rdata = cmem[cfg_addr];
    always @(posedge clk) begin
        if (cfg_we) begin
            cmem[cfg_addr] <= cfg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (nv_set)      nv_flag <= 1'b1;
        else if (nv_clr) nv_flag <= 1'b0;
        if (done) done_cnt <= done_cnt + 1;
    end
    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int b = 0; b < 4; b++) fmem[(a + b) % 1024] = w[31-8*b -: 8];
    endtask

    function automatic logic [31:0] get_word(input int a);
        return {fmem[a % 1024], fmem[(a+1) % 1024], fmem[(a+2) % 1024], fmem[(a+3) % 1024]};
    endfunction

    // kind: 0 well formed, 1 wrong identifier, 2 wrong checksum.
    task automatic gen_img(input int base, input int len, input int kind);
        logic [31:0] s = 32'd0;
        logic [31:0] w;
        put_word(base, kind == 1 ? DEV_ID ^ 32'h10 : DEV_ID);
        put_word(base + 4, 32'(len));
        for (int i = 0; i < len; i++) begin
            w = $urandom;
            s += w;
            put_word(base + 8 + 4*i, w);
        end
        put_word(base + 8 + 4*len, kind == 2 ? s + 32'd1 : s);
    endtask

    function automatic logic [1:0] exp_status(input logic [1:0] op, input int base);
        logic [31:0] len = get_word(base + 4);
        logic [31:0] s = 32'd0;
        bit mis = 0;
        if (op == 2'b00) return 2'd3;
        if (get_word(base) != DEV_ID || len > 32'(DEPTH)) return 2'd1;
        for (int i = 0; i < int'(len); i++) begin
            s += get_word(base + 8 + 4*i);
            if (get_word(base + 8 + 4*i) != exp_cfg[i]) mis = 1;
        end
        if (s != get_word(base + 8 + 4*int'(len))) return 2'd2;
        if (op == 2'b11 && mis) return 2'd2;
        return 2'd0;
    endfunction

    function automatic bit img_ok_hdr(input int base);
        return get_word(base) == DEV_ID && get_word(base + 4) <= 32'(DEPTH);
    endfunction

    task automatic load_exp(input int base);
        if (img_ok_hdr(base))
            for (int i = 0; i < int'(get_word(base + 4)); i++) exp_cfg[i] = get_word(base + 8 + 4*i);
    endtask

    function automatic bit cfg_match();
        for (int i = 0; i < DEPTH; i++) if (cmem[i] !== exp_cfg[i]) return 0;
        return 1;
    endfunction

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic start_req(input logic [1:0] op, input int addr);
        wait_idle();
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_req(input logic [1:0] op, input int addr, output logic [1:0] st, output int nwr);
        int t = 0;
        int n0;
        wait_idle();
        n0 = wr_cnt;
        start_req(op, addr);
        while (!done && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) check(0, "R11 timeout", 32'(t), 32'd0);
        st = status;
        nwr = wr_cnt - n0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs one request and checks status, writes, persistent bit and fabric.
    task automatic run_and_check(input logic [1:0] op, input int base, input string tag);
        logic [1:0] st, es;
        int nwr, ewr;
        bit env;
        es  = exp_status(op, base);
        env = nv_flag;
        ewr = 0;
        if (op == 2'b10 && img_ok_hdr(base)) begin
            ewr = int'(get_word(base + 4));
            env = (es != 2'd0);
            load_exp(base);
        end
        do_req(op, base, st, nwr);
        check(st == es, {tag, " status"}, 32'(st), 32'(es));
        check(nwr == ewr, {tag, " write count R3 R5 R6 R8"}, 32'(nwr), 32'(ewr));
        check(nv_flag == env, {tag, " persistent bit R7"}, 32'(nv_flag), 32'(env));
        check(fabric_rel == !env, {tag, " fabric R11"}, 32'(fabric_rel), 32'(!env));
        if (op == 2'b10) check(cfg_match(), {tag, " cfg contents R6"}, 32'(cfg_match()), 32'd1);
    endtask

    // Interrupts a program run, then recovers across a reset from the chosen image.
    task automatic power_cut_and_recover(input bit sel, input string tag);
        int n0;
        int t = 0;
        bit held_low = 1;
        gen_img(WORK, DEPTH, 0);
        n0 = wr_cnt;
        start_req(2'b10, WORK);
        while (wr_cnt - n0 < 3 && t < 5000) begin @(negedge clk); t++; end
        power_fail = 1'b1;
        @(negedge clk);
        check(pump_en == 1'b0, {tag, " R9 pump off next cycle"}, 32'(pump_en), 32'd0);
        n0 = wr_cnt;
        repeat (60) @(negedge clk);
        check(busy == 1'b1, {tag, " R9 stays busy"}, 32'(busy), 32'd1);
        check(wr_cnt == n0 && !fl_req, {tag, " R9 frozen"}, 32'(wr_cnt - n0), 32'd0);
        check(nv_flag == 1'b1, {tag, " R7 bit left set"}, 32'(nv_flag), 32'd1);
        power_fail = 1'b0;
        recov_sel = sel;
        do_reset();
        t = 0;
        while ((busy || nv_flag) && t < 5000) begin
            @(negedge clk); t++;
            if (fabric_rel && nv_flag) held_low = 0;
        end
        check(held_low, {tag, " R10 fabric held during recovery"}, 32'(held_low), 32'd1);
        repeat (3) @(negedge clk);
        load_exp(sel ? UPD : GOLD);
        check(cfg_match(), {tag, " R10 cfg from selected image"}, 32'(cfg_match()), 32'd1);
        check(nv_flag == 1'b0 && fabric_rel, {tag, " R10 released"}, {30'd0, nv_flag, fabric_rel}, 32'd1);
    endtask

    initial begin
        int unsigned seed;
        int d0;
        logic [31:0] w;
        seed = $urandom(32'd1234);
        for (int i = 0; i < 1024; i++) fmem[i] = 8'hFF;
        for (int i = 0; i < DEPTH; i++) begin cmem[i] = '0; exp_cfg[i] = '0; end
        gen_img(GOLD, 12, 0);
        gen_img(UPD, DEPTH, 0);
        do_reset();
        repeat (4) @(negedge clk);
        // Reset state.
        check(!busy && !done && !pump_en && !cfg_we, "R11 reset outputs idle",
              {28'd0, busy, done, pump_en, cfg_we}, 32'd0);
        check(fabric_rel == 1'b1, "R10 release with bit clear", 32'(fabric_rel), 32'd1);

        // R1 bad operation code.
        run_and_check(2'b00, WORK, "R1 bad op");
        // R2 well-formed image, check only.
        gen_img(WORK, 5, 0);
        run_and_check(2'b01, WORK, "R2 R5 auth good");
        // R3 wrong identifier and oversize length.
        gen_img(WORK, 4, 1);
        run_and_check(2'b01, WORK, "R3 auth bad id");
        run_and_check(2'b10, WORK, "R3 prog bad id");
        gen_img(WORK, DEPTH + 1, 0);
        run_and_check(2'b10, WORK, "R3 prog too long");
        // R4 checksum mismatch.
        gen_img(WORK, 7, 2);
        run_and_check(2'b01, WORK, "R4 auth bad sum");
        // R6 R7 full-depth program then R8 verify.
        gen_img(WORK, DEPTH, 0);
        run_and_check(2'b10, WORK, "R6 R7 prog full");
        run_and_check(2'b11, WORK, "R8 verify match");
        w = get_word(WORK + 8) ^ 32'h1;
        put_word(WORK + 8 + 4*DEPTH, get_word(WORK + 8 + 4*DEPTH) - get_word(WORK + 8) + w);
        put_word(WORK + 8, w);
        run_and_check(2'b11, WORK, "R8 verify mismatch");
        // R7 failed program leaves bit set and fabric held.
        gen_img(WORK, 3, 2);
        run_and_check(2'b10, WORK, "R7 prog bad sum");
        gen_img(WORK, 6, 0);
        run_and_check(2'b10, WORK, "R7 prog clears bit");

        // R11 request during a run is dropped.
        gen_img(WORK, 8, 0);
        d0 = done_cnt;
        start_req(2'b10, WORK);
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        check(done_cnt - d0 == 1, "R11 busy request dropped", 32'(done_cnt - d0), 32'd1);
        load_exp(WORK);

        // R9 R10 power failure and recovery from each source.
        power_cut_and_recover(1'b1, "update");
        power_cut_and_recover(1'b0, "golden");

        // Random mix of operations and image faults.
        for (int it = 0; it < 24; it++) begin
            int r, len, kind;
            logic [1:0] op;
            r = $urandom_range(0, 9);
            kind = (r < 6) ? 0 : (r < 8 ? 2 : 1);
            len = $urandom_range(1, DEPTH + 1);
            if ($urandom_range(0, 1) == 0 || it == 0) gen_img(WORK, len, kind);
            op = 2'($urandom_range(0, 3));
            run_and_check(op, WORK, "R1 R2 R4 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule